// File: doc/BRIEF.md
# Segment Protection and Limit Checker

This block screens one memory access per cycle against the attributes of the segment it names. It applies only while protected mode is on and long mode is off. It raises a general-protection fault for any of these cases:
- a zero selector on a segment that needs one;
- a read or write that the segment's permissions forbid;
- an access that reaches outside the range the segment's limit allows.

A normal segment allows the range up to the limit. An expand-down segment allows only the range above it.

The offset is the linear address minus the segment base, reduced to the effective address width. The effective width comes from a default size code, or from an alternate code when the request carries an address-size override. The block also produces the address to pass onward. That address is cut to 32 bits when the core is not in its 64-bit submode, or when the override is set. The fault is available combinationally in the request cycle. A registered copy of the result, with the address, follows one cycle later.

Top module: `seg_guard`

## Requirements
- R1: With prot_en low, or with long_mode high, gp_fault and rsp_fault stay low whatever the selector, attributes or limit. With prot_en low, rsp_addr equals vaddr unchanged.
- R2: A zero selector faults, except on the exempt segment indices 6, 8, 9 and 10, which never fault for a zero selector.
- R3: On a data-class segment (index 0 to 6), an access with acc_mode write (2'b01) or with store_chk set faults when attr_wr is low. Segments with index 7 and above ignore attr_wr.
- R4: On a data-class segment, an access with acc_mode read (2'b00) faults when attr_rd is low. Execute (2'b10) ignores attr_rd.
- R5: The offset width is 8·2^log bits. The log is def_log, or alt_log when asz_ovr is set, with codes 0 to 3 meaning 8, 16, 32 and 64 bits. The offset is (vaddr − seg_base) modulo 2^width.
- R6: On a segment with attr_xd low, the access faults when the start offset or the end offset (offset + acc_size − 1) is greater than seg_limit.
- R7: On a segment with attr_xd high (expand-down), the access faults when the start offset or the end offset is less than or equal to seg_limit. The flag is honoured only on data-class segments.
- R8: With prot_en high, rsp_addr is vaddr masked to its low 32 bits when sub64 is low or asz_ovr is high. Otherwise rsp_addr is vaddr unchanged.
- R9: gp_fault is combinational and qualified by req_valid. rsp_valid, rsp_fault and rsp_addr register the request one clock later. Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| seg_idx | input | 4 | Segment index |
| seg_sel | input | 16 | Segment selector value |
| attr_rd | input | 1 | Segment readable |
| attr_wr | input | 1 | Segment writable |
| attr_xd | input | 1 | Segment expands downward |
| seg_base | input | 64 | Segment base |
| seg_limit | input | 64 | Segment limit |
| acc_mode | input | 2 | 00 read, 01 write, 10 execute |
| store_chk | input | 1 | Check as if the access were a store |
| acc_size | input | 4 | Access size in bytes (1 to 8) |
| asz_ovr | input | 1 | Address-size override |
| def_log | input | 2 | Default address-size code |
| alt_log | input | 2 | Alternate address-size code |
| prot_en | input | 1 | Protected mode on |
| long_mode | input | 1 | Long mode on |
| sub64 | input | 1 | 64-bit submode |
| vaddr | input | 64 | Linear address of the access |
| gp_fault | output | 1 | Combinational protection fault |
| rsp_valid | output | 1 | Registered result valid |
| rsp_fault | output | 1 | Registered fault |
| rsp_addr | output | 64 | Registered adjusted address |

## Verification
Limit checks are tried at the exact boundary: an end offset equal to the limit passes, and one byte past it fails. The expand-down case is tried at limit and at limit + 1, which separates a strict comparison from a non-strict one. A start offset inside the segment with an end offset outside it catches a design that tests only one end. An address that wraps below the base under a 16-bit width, and the same address under the override with a 32-bit width, show that the offset is reduced modulo the selected width. Zero selectors on exempt and non-exempt indices, and read, write, store-check and execute against cleared permission bits, show that each check fires only where it applies.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10
  } acc_mode_e;

  // segments 0..DATA_LAST carry read/write/expand-down attributes
  localparam int unsigned DATA_LAST = 6;
  // segment indices excused from the zero-selector check
  localparam logic [15:0] NULL_EXEMPT = 16'b0000_0111_0100_0000;
endpackage

// File: rtl/seg_perm_check.sv
module seg_perm_check
  import seg_guard_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SEL_W = 16
) (
  input  logic [IDX_W-1:0] seg_idx,
  input  logic [SEL_W-1:0] seg_sel,
  input  logic             attr_rd,
  input  logic             attr_wr,
  input  logic [1:0]       acc_mode,
  input  logic             store_chk,
  output logic             data_class,
  output logic             perm_fault
);
  logic exempt, null_f, wr_f, rd_f;

  always_comb begin
    exempt     = (int'(seg_idx) < 16) ? NULL_EXEMPT[seg_idx] : 1'b0;
    data_class = (int'(seg_idx) <= int'(DATA_LAST));
    null_f     = !exempt && (seg_sel == '0);
    wr_f       = data_class && !attr_wr &&
                 ((acc_mode == ACC_WRITE) || store_chk);
    rd_f       = data_class && !attr_rd && (acc_mode == ACC_READ);
    perm_fault = null_f || wr_f || rd_f;
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
  parameter int AW     = 64,
  parameter int SIZE_W = 4
) (
  input  logic [AW-1:0]     vaddr,
  input  logic [AW-1:0]     seg_base,
  input  logic [AW-1:0]     seg_limit,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [1:0]        size_log,
  input  logic              expand_down,
  output logic              limit_fault
);
  logic [AW-1:0] wmask, offs, offs_end;
  logic [7:0]    wbits;

  always_comb begin
    wbits    = 8'd8 << size_log;
    wmask    = ~({AW{1'b1}} << wbits);
    offs     = (vaddr - seg_base) & wmask;
    offs_end = offs + AW'(acc_size) - AW'(1);
    if (expand_down)
      limit_fault = (offs <= seg_limit) || (offs_end <= seg_limit);
    else
      limit_fault = (offs > seg_limit) || (offs_end > seg_limit);
  end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int AW     = 64,
  parameter int IDX_W  = 4,
  parameter int SEL_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  seg_idx,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic              attr_rd,
  input  logic              attr_wr,
  input  logic              attr_xd,
  input  logic [AW-1:0]     seg_base,
  input  logic [AW-1:0]     seg_limit,
  input  logic [1:0]        acc_mode,
  input  logic              store_chk,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              asz_ovr,
  input  logic [1:0]        def_log,
  input  logic [1:0]        alt_log,
  input  logic              prot_en,
  input  logic              long_mode,
  input  logic              sub64,
  input  logic [AW-1:0]     vaddr,
  output logic              gp_fault,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [AW-1:0]     rsp_addr
);
  localparam int NARROW = (AW < 32) ? AW : 32;

  logic          data_class, perm_f, lim_f, checks_on, fault_c, narrow;
  logic [1:0]    size_log;
  logic [AW-1:0] addr_c;

  seg_perm_check #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_perm (
    .seg_idx    (seg_idx),
    .seg_sel    (seg_sel),
    .attr_rd    (attr_rd),
    .attr_wr    (attr_wr),
    .acc_mode   (acc_mode),
    .store_chk  (store_chk),
    .data_class (data_class),
    .perm_fault (perm_f)
  );

  seg_limit_check #(.AW(AW), .SIZE_W(SIZE_W)) u_lim (
    .vaddr       (vaddr),
    .seg_base    (seg_base),
    .seg_limit   (seg_limit),
    .acc_size    (acc_size),
    .size_log    (size_log),
    .expand_down (attr_xd && data_class),
    .limit_fault (lim_f)
  );

  always_comb begin
    size_log  = asz_ovr ? alt_log : def_log;
    checks_on = prot_en && !long_mode;
    fault_c   = req_valid && checks_on && (perm_f || lim_f);
    narrow    = prot_en && (!sub64 || asz_ovr);
    addr_c    = vaddr;
    if (narrow)
      addr_c = vaddr & AW'({NARROW{1'b1}});
  end

  assign gp_fault = fault_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= fault_c;
      rsp_addr  <= addr_c;
    end
  end
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          prot_en,
  input logic          long_mode,
  input logic          sub64,
  input logic          asz_ovr,
  input logic [AW-1:0] vaddr,
  input logic          gp_fault,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic [AW-1:0] rsp_addr
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rsp_valid == $past(req_valid)));

  assert_fault_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid);

  assert_comb_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !gp_fault);

  assert_no_fault_unchecked_R1: assert property (@(posedge clk) disable iff (rst)
    (!prot_en || long_mode) |-> !gp_fault);

  assert_real_mode_pass_R1: assert property (@(posedge clk) disable iff (rst)
    !prot_en |=> (rsp_addr == $past(vaddr)));

  assert_narrow_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (prot_en && (!sub64 || asz_ovr)) |=> (rsp_addr[AW-1:32] == '0));
endmodule

bind seg_guard seg_guard_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .prot_en   (prot_en),
  .long_mode (long_mode),
  .sub64     (sub64),
  .asz_ovr   (asz_ovr),
  .vaddr     (vaddr),
  .gp_fault  (gp_fault),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_addr  (rsp_addr)
);

// File: tb/seg_guard_test.sv
module seg_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid;
  logic [3:0]  seg_idx;
  logic [15:0] seg_sel;
  logic        attr_rd, attr_wr, attr_xd;
  logic [63:0] seg_base, seg_limit, vaddr;
  logic [1:0]  acc_mode, def_log, alt_log;
  logic        store_chk, asz_ovr, prot_en, long_mode, sub64;
  logic [3:0]  acc_size;
  logic        gp_fault, rsp_valid, rsp_fault;
  logic [63:0] rsp_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  seg_guard uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .seg_idx(seg_idx),
    .seg_sel(seg_sel), .attr_rd(attr_rd), .attr_wr(attr_wr),
    .attr_xd(attr_xd), .seg_base(seg_base), .seg_limit(seg_limit),
    .acc_mode(acc_mode), .store_chk(store_chk), .acc_size(acc_size),
    .asz_ovr(asz_ovr), .def_log(def_log), .alt_log(alt_log),
    .prot_en(prot_en), .long_mode(long_mode), .sub64(sub64),
    .vaddr(vaddr), .gp_fault(gp_fault), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic defaults();
    req_valid = 1'b1; seg_idx = 4'd3; seg_sel = 16'h0010;
    attr_rd = 1'b1; attr_wr = 1'b1; attr_xd = 1'b0;
    seg_base = 64'h1000; seg_limit = 64'hFF; vaddr = 64'h1000;
    acc_mode = 2'b00; store_chk = 1'b0; acc_size = 4'd1;
    asz_ovr = 1'b0; def_log = 2'd2; alt_log = 2'd2;
    prot_en = 1'b1; long_mode = 1'b0; sub64 = 1'b0;
  endtask

  // inputs already set (after a negedge); check comb, then registered
  task automatic run(input string req, input logic exp_f,
                     input logic [63:0] exp_a);
    #1 check({req, " comb"}, 64'(gp_fault), 64'(exp_f));
    @(posedge clk); #1;
    check({req, " reg"}, 64'(rsp_fault), 64'(exp_f));
    check({req, " addr"}, rsp_addr, exp_a);
    @(negedge clk);
    defaults();
  endtask

  task automatic t_reset();
    check("R9 reset valid", 64'(rsp_valid), 64'd0);
    check("R9 reset fault", 64'(rsp_fault), 64'd0);
    check("R9 reset addr", rsp_addr, 64'd0);
  endtask

  task automatic t_timing();
    seg_sel = 16'h0; req_valid = 1'b0;
    #1 check("R9 idle comb", 64'(gp_fault), 64'd0);
    @(posedge clk); #1 check("R9 idle valid", 64'(rsp_valid), 64'd0);
    @(negedge clk); req_valid = 1'b1;
    @(posedge clk); #1 check("R9 valid next", 64'(rsp_valid), 64'd1);
    @(negedge clk); defaults();
  endtask

  task automatic t_disabled();
    prot_en = 1'b0; seg_sel = 16'h0; seg_limit = 64'h0;
    vaddr = 64'h1_2345_6789;
    run("R1 prot off", 1'b0, 64'h1_2345_6789);
    long_mode = 1'b1; seg_sel = 16'h0; attr_rd = 1'b0; sub64 = 1'b1;
    vaddr = 64'h1_2345_6789;
    run("R1 long mode", 1'b0, 64'h1_2345_6789);
  endtask

  task automatic t_null();
    seg_sel = 16'h0;
    run("R2 null data seg", 1'b1, 64'h1000);
    for (int i = 0; i < 16; i++) begin
      if (i >= 7) begin
        seg_idx = 4'(i); seg_sel = 16'h0;
        run($sformatf("R2 idx %0d", i), (i == 8 || i == 9 || i == 10)
            ? 1'b0 : 1'b1, 64'h1000);
      end
    end
    seg_idx = 4'd6; seg_sel = 16'h0;
    run("R2 exempt idx6", 1'b0, 64'h1000);
  endtask

  task automatic t_perm();
    attr_wr = 1'b0; acc_mode = 2'b01;
    run("R3 write ro", 1'b1, 64'h1000);
    attr_wr = 1'b0; store_chk = 1'b1;
    run("R3 store check ro", 1'b1, 64'h1000);
    attr_wr = 1'b0;
    run("R3 read ro ok", 1'b0, 64'h1000);
    attr_wr = 1'b0; acc_mode = 2'b01; seg_idx = 4'd7;
    run("R3 non-data ignores wr", 1'b0, 64'h1000);
    attr_rd = 1'b0;
    run("R4 read unreadable", 1'b1, 64'h1000);
    attr_rd = 1'b0; acc_mode = 2'b10;
    run("R4 exec ignores rd", 1'b0, 64'h1000);
  endtask

  task automatic t_limit();
    vaddr = 64'h10FC; acc_size = 4'd4;
    run("R6 end at limit", 1'b0, 64'h10FC);
    vaddr = 64'h10FC; acc_size = 4'd8;
    run("R6 end past limit", 1'b1, 64'h10FC);
    vaddr = 64'h1100;
    run("R6 start past limit", 1'b1, 64'h1100);
    attr_xd = 1'b1; vaddr = 64'h1100; acc_size = 4'd4;
    run("R7 xd above limit", 1'b0, 64'h1100);
    attr_xd = 1'b1; vaddr = 64'h10FF;
    run("R7 xd at limit", 1'b1, 64'h10FF);
    attr_xd = 1'b1; vaddr = 64'h10F0;
    run("R7 xd below", 1'b1, 64'h10F0);
  endtask

  task automatic t_width();
    def_log = 2'd1; seg_limit = 64'h20; vaddr = 64'h1_1010;
    run("R5 16-bit wrap in", 1'b0, 64'h1_1010);
    def_log = 2'd1; seg_limit = 64'h20; vaddr = 64'h1_1010;
    asz_ovr = 1'b1; alt_log = 2'd2;
    run("R5 override 32-bit", 1'b1, 64'h1_1010);
    def_log = 2'd1; seg_limit = 64'h20; vaddr = 64'h0FF0;
    run("R5 below base wraps", 1'b1, 64'h0FF0);
  endtask

  task automatic t_trunc();
    seg_base = 64'h0; seg_limit = '1; vaddr = 64'h1_2345_6789;
    run("R8 narrow submode", 1'b0, 64'h2345_6789);
    seg_base = 64'h0; seg_limit = '1; vaddr = 64'h1_2345_6789;
    sub64 = 1'b1; def_log = 2'd3;
    run("R8 64-bit submode", 1'b0, 64'h1_2345_6789);
    seg_base = 64'h0; seg_limit = '1; vaddr = 64'h1_2345_6789;
    sub64 = 1'b1; asz_ovr = 1'b1; alt_log = 2'd2;
    run("R8 override narrows", 1'b0, 64'h2345_6789);
  endtask

  initial begin
    defaults();
    #200_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst = 1'b0;
    t_timing();
    t_disabled();
    t_null();
    t_perm();
    t_limit();
    t_width();
    t_trunc();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule